// File: doc/BRIEF.md
# I2C Command-Queue Register Front End

This block is the register-mapped control side of a queue-driven I2C master. Software writes command words into a transfer queue. Each word holds one data byte plus two request bits: one to open with a START condition and one to finish with a STOP condition. A bit-level serial engine takes these words from the queue. The engine hands received bytes back into a receive queue, which software drains through a read-data register. The engine also reports arbitration loss and missing acknowledge as single-cycle pulses.

The block decodes a 32-bit register bus on word offsets. It keeps the control and interrupt-enable registers and reports the fill level of both queues. It derives two ready flags from programmable queue thresholds and latches the error causes as sticky flags. A single interrupt line is driven from the enabled causes.

Back-pressure rules:
- Engine side of the command queue: a word moves on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_valid` is high only while the core is enabled and the queue is non-empty. `cmd_data` holds steady until the word is taken.
- Receive side: the engine cannot be stalled. A byte presented while the receive queue is full is lost, and the loss is recorded as a flag.
- Register bus: it has no wait states. Read data is combinational in the cycle `reg_rd` is high.

Top module: `i2cq_regs`

## Requirements
- R1: After reset every register reads 0, both levels are 0, and `irq`, `cmd_valid`, `core_en` and `fast_mode` are low.
- R2: Command words use this layout: bit 9 requests START, bit 8 requests STOP, bits 7:0 are the byte. A write to word offset 0x00 while enabled queues bits 9:0. The engine receives the words on `cmd_data`, in write order, one per `cmd_valid && cmd_ready` cycle. Offset 0x18 reports the command queue level.
- R3: A command write while the command queue holds DEPTH words is dropped, and the level stays at DEPTH.
- R4: Received bytes read out of offset 0x04 in arrival order, and each read removes one byte. A read of an empty queue returns 0. Offset 0x1C reports the receive queue level.
- R5: A byte that arrives while enabled with the receive queue full is discarded and sets status bit 4 (receive overflow). The queued bytes are unchanged.
- R6: Interrupt-status bit 0 (transmit ready) is 1 while the core is enabled and the command level is at or below control bits 3:2.
- R7: Interrupt-status bit 1 (receive ready) is 1 while the core is enabled and the receive level is above control bits 5:4.
- R8: Interrupt-status bits 4, 3 and 2 hold the causes. Bit 4 is overflow, bit 3 is arbitration lost (set by `evt_arb`) and bit 2 is NACK (set by `evt_nack`). These bits stay set until a write to offset 0x10 with a 1 in their position. Writing bits 1:0 has no effect.
- R9: `irq` is high exactly when some bit of the interrupt status (0x10) and the same bit of the interrupt enable (0x0C, bits 4:0) are both 1.
- R10: Writing control bit 0 to 0 empties both queues. While it is 0, command writes and engine bytes are ignored, and no overflow is flagged.
- R11: Status (0x14) bit 0 is 1 while enabled and either `eng_busy` is high or the command queue is non-empty; otherwise it is 0.
- R12: Control (0x08) bits 5:0 read back as written. Bit 0 drives `core_en` and bit 1 drives `fast_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x04) |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| cmd_valid | output | 1 | Command word available to engine |
| cmd_ready | input | 1 | Engine takes the word |
| cmd_data | output | 10 | START, STOP, byte |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| evt_arb | input | 1 | Arbitration-lost pulse |
| evt_nack | input | 1 | NACK pulse |
| eng_busy | input | 1 | Engine is mid-transfer |
| core_en | output | 1 | Core enable to engine |
| fast_mode | output | 1 | Fast bus speed select |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default queue depth of 4. At that depth, a queue goes from empty to full in a handful of writes. This makes it practical to sweep every threshold setting (0 to 3) against every fill level (0 to 4) for both ready flags. Each sweep pushes the receive queue one byte past full to reach the overflow path. The 5-bit interrupt-enable field is small enough to try all 32 masks against a fixed status pattern.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  // word index = byte address >> 2
  localparam logic [2:0] IX_CMD    = 3'd0;
  localparam logic [2:0] IX_RXD    = 3'd1;
  localparam logic [2:0] IX_CTRL   = 3'd2;
  localparam logic [2:0] IX_IEN    = 3'd3;
  localparam logic [2:0] IX_ISTAT  = 3'd4;
  localparam logic [2:0] IX_STAT   = 3'd5;
  localparam logic [2:0] IX_CLVL   = 3'd6;
  localparam logic [2:0] IX_RLVL   = 3'd7;

  localparam int CMD_W   = 10;
  localparam int CTRL_W  = 6;
  localparam int INT_W   = 5;

  // interrupt bit positions
  localparam int B_TXR  = 0;
  localparam int B_RXR  = 1;
  localparam int B_NACK = 2;
  localparam int B_ARB  = 3;
  localparam int B_OVF  = 4;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_irq.sv
module i2cq_irq
  import i2cq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ovf,
  input  logic             set_arb,
  input  logic             set_nack,
  input  logic             clr_wr,
  input  logic [INT_W-1:0] clr_bits,
  input  logic             tx_rdy,
  input  logic             rx_rdy,
  input  logic [INT_W-1:0] ien,
  output logic [INT_W-1:0] istat,
  output logic             irq
);
  logic ovf_q, arb_q, nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      arb_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      // a new event in the same cycle as a clear wins
      ovf_q  <= set_ovf  | (ovf_q  & ~(clr_wr & clr_bits[B_OVF]));
      arb_q  <= set_arb  | (arb_q  & ~(clr_wr & clr_bits[B_ARB]));
      nack_q <= set_nack | (nack_q & ~(clr_wr & clr_bits[B_NACK]));
    end
  end

  always_comb begin
    istat         = '0;
    istat[B_TXR]  = tx_rdy;
    istat[B_RXR]  = rx_rdy;
    istat[B_NACK] = nack_q;
    istat[B_ARB]  = arb_q;
    istat[B_OVF]  = ovf_q;
  end

  assign irq = |(istat & ien);
endmodule

// File: rtl/i2cq_regs.sv
module i2cq_regs
  import i2cq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              evt_arb,
  input  logic              evt_nack,
  input  logic              eng_busy,
  output logic              core_en,
  output logic              fast_mode,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [INT_W-1:0]  ien_q;
  logic [INT_W-1:0]  isr;
  logic [2:0]        idx;
  logic              wr_cmd, wr_ctrl, wr_ien, wr_isr, rd_rxd;
  logic              flush;
  logic [LVL_W-1:0]  cmd_lvl, rx_lvl;
  logic              cmd_full, cmd_empty, rx_full, rx_empty;
  logic [7:0]        rx_dout;
  logic              tx_rdy, rx_rdy, ovf_evt;

  assign idx     = reg_addr[4:2];
  assign wr_cmd  = reg_wr && (idx == IX_CMD);
  assign wr_ctrl = reg_wr && (idx == IX_CTRL);
  assign wr_ien  = reg_wr && (idx == IX_IEN);
  assign wr_isr  = reg_wr && (idx == IX_ISTAT);
  assign rd_rxd  = reg_rd && (idx == IX_RXD);

  assign core_en   = ctrl_q[0];
  assign fast_mode = ctrl_q[1];
  assign flush     = !ctrl_q[0] || (wr_ctrl && !reg_wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (wr_ien)  ien_q  <= reg_wdata[INT_W-1:0];
    end
  end

  i2cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(wr_cmd), .din(reg_wdata[CMD_W-1:0]),
    .pop(cmd_valid && cmd_ready), .dout(cmd_data),
    .level(cmd_lvl), .full(cmd_full), .empty(cmd_empty)
  );

  i2cq_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_valid), .din(rx_data),
    .pop(rd_rxd), .dout(rx_dout),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  assign cmd_valid = core_en && !cmd_empty;
  assign ovf_evt   = rx_valid && core_en && rx_full && !flush;
  assign tx_rdy    = core_en && (int'(cmd_lvl) <= int'(ctrl_q[3:2]));
  assign rx_rdy    = core_en && (int'(rx_lvl) > int'(ctrl_q[5:4]));

  i2cq_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_ovf(ovf_evt), .set_arb(evt_arb), .set_nack(evt_nack),
    .clr_wr(wr_isr), .clr_bits(reg_wdata[INT_W-1:0]),
    .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .ien(ien_q),
    .istat(isr), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (idx)
      IX_RXD:   reg_rdata[7:0]        = rx_empty ? 8'h00 : rx_dout;
      IX_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
      IX_IEN:   reg_rdata[INT_W-1:0]  = ien_q;
      IX_ISTAT: reg_rdata[INT_W-1:0]  = isr;
      IX_STAT:  reg_rdata[0]          = core_en && (eng_busy || !cmd_empty);
      IX_CLVL:  reg_rdata[LVL_W-1:0]  = cmd_lvl;
      IX_RLVL:  reg_rdata[LVL_W-1:0]  = rx_lvl;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cq_regs_chk.sv
module i2cq_regs_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_en,
  input logic              cmd_valid,
  input logic              rx_valid,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [LVL_W-1:0]  cmd_lvl,
  input logic [LVL_W-1:0]  rx_lvl,
  input logic [4:0]        isr,
  input logic [4:0]        ien,
  input logic              irq
);
  logic isr_wr;
  assign isr_wr = reg_wr && (reg_addr[4:2] == 3'd4);

  // R2: words are offered only from a non-empty queue of an enabled core
  a_r2_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (core_en && cmd_lvl != '0));

  // R3: levels never pass the depth
  a_r3_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lvl <= LVL_W'(DEPTH)) && (rx_lvl <= LVL_W'(DEPTH)));

  // R5: a byte into a full queue raises the overflow flag
  a_r5_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && rx_valid && rx_lvl == LVL_W'(DEPTH)) |=> isr[4]);

  // R7: no receive-ready with an empty receive queue
  a_r7_rx_rdy_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl == '0) |-> !isr[1]);

  // R8: arbitration flag holds unless cleared by a 1
  a_r8_arb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[3] && !(isr_wr && reg_wdata[3])) |=> isr[3]);

  // R9: no interrupt with all enables low
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  // R10: a disabled core holds empty queues
  a_r10_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> (cmd_lvl == '0 && rx_lvl == '0));
endmodule

bind i2cq_regs i2cq_regs_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .cmd_valid(cmd_valid),
  .rx_valid(rx_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_lvl(cmd_lvl), .rx_lvl(rx_lvl),
  .isr(isr), .ien(ien_q), .irq(irq)
);

// File: tb/i2cq_regs_tb.sv
module i2cq_regs_tb;
  localparam int DEPTH = 4;
  localparam logic [4:0] A_CMD = 5'h00, A_RXD = 5'h04, A_CTRL = 5'h08,
                         A_IEN = 5'h0C, A_ISR = 5'h10, A_STAT = 5'h14,
                         A_CLVL = 5'h18, A_RLVL = 5'h1C;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid, cmd_ready = 0;
  logic [9:0] cmd_data;
  logic rx_valid = 0;
  logic [7:0] rx_data = '0;
  logic evt_arb = 0, evt_nack = 0, eng_busy = 0;
  logic core_en, fast_mode, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2cq_regs #(.DEPTH(DEPTH), .ADDR_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .evt_arb(evt_arb),
    .evt_nack(evt_nack), .eng_busy(eng_busy), .core_en(core_en),
    .fast_mode(fast_mode), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic pulse(input bit arb, input bit nack);
    @(negedge clk);
    evt_arb = arb; evt_nack = nack;
    @(posedge clk); #1;
    evt_arb = 0; evt_nack = 0;
  endtask

  task automatic take(output bit v, output logic [9:0] d);
    @(negedge clk);
    cmd_ready = 1;
    #1 v = cmd_valid; d = cmd_data;
    @(posedge clk); #1;
    cmd_ready = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit v;
    logic [9:0] cw;
    logic [9:0] words [4];
    words[0] = 10'h2A5; words[1] = 10'h011; words[2] = 10'h1FF; words[3] = 10'h000;

    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), d);
      chk("R1 reg", int'(d), 0);
    end
    chk("R1 irq", int'(irq), 0);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 core_en/fast", int'({core_en, fast_mode}), 0);

    // R12 control readback
    wr(A_CTRL, 32'h3B);
    rd(A_CTRL, d);
    chk("R12 ctrl", int'(d), 'h3B);
    chk("R12 pins", int'({core_en, fast_mode}), 3);
    wr(A_CTRL, 32'h0);
    chk("R12 disabled", int'({core_en, fast_mode}), 0);

    // R2 / R3 / R11 command path
    wr(A_CTRL, 32'h1);
    rd(A_STAT, d);
    chk("R11 idle", int'(d), 0);
    for (int k = 0; k < 4; k++) wr(A_CMD, 32'(words[k]));
    rd(A_CLVL, d);
    chk("R2 level", int'(d), 4);
    wr(A_CMD, 32'h123);
    rd(A_CLVL, d);
    chk("R3 full drop", int'(d), 4);
    rd(A_STAT, d);
    chk("R11 busy queue", int'(d), 1);
    for (int k = 0; k < 4; k++) begin
      take(v, cw);
      chk("R2 valid", int'(v), 1);
      chk("R2 word", int'(cw), int'(words[k]));
    end
    @(negedge clk);
    chk("R2 drained", int'(cmd_valid), 0);
    rd(A_STAT, d);
    chk("R11 idle after", int'(d), 0);
    eng_busy = 1;
    rd(A_STAT, d);
    chk("R11 engine busy", int'(d), 1);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, d);
    chk("R11 disabled", int'(d), 0);
    eng_busy = 0;

    // R10 disable flush and ignore
    wr(A_CTRL, 32'h1);
    wr(A_CMD, 32'h055); wr(A_CMD, 32'h066);
    rx_push(8'h11); rx_push(8'h22);
    wr(A_CTRL, 32'h0);
    rd(A_CLVL, d); chk("R10 cmd flushed", int'(d), 0);
    rd(A_RLVL, d); chk("R10 rx flushed", int'(d), 0);
    chk("R10 no valid", int'(cmd_valid), 0);
    wr(A_CMD, 32'h077);
    for (int k = 0; k < 6; k++) rx_push(8'h33);
    wr(A_CTRL, 32'h1);
    rd(A_CLVL, d); chk("R10 cmd ignored", int'(d), 0);
    rd(A_RLVL, d); chk("R10 rx ignored", int'(d), 0);
    rd(A_ISR, d);  chk("R10 no ovf", int'(d[4]), 0);
    wr(A_CTRL, 32'h0);

    // R6 transmit-ready sweep
    for (int t = 0; t < 4; t++) begin
      wr(A_CTRL, 32'((t << 2) | 1));
      for (int l = 0; l <= DEPTH; l++) begin
        if (l > 0) wr(A_CMD, 32'(l));
        rd(A_ISR, d);
        chk("R6 txrdy", int'(d[0]), (l <= t) ? 1 : 0);
      end
      wr(A_CTRL, 32'h0);
      rd(A_ISR, d);
      chk("R6 off", int'(d[0]), 0);
    end

    // R7 / R5 / R4 receive sweep
    for (int t = 0; t < 4; t++) begin
      wr(A_CTRL, 32'((t << 4) | 1));
      for (int l = 0; l <= DEPTH; l++) begin
        if (l > 0) rx_push(8'(8'h40 + t * 8 + l - 1));
        rd(A_RLVL, d);
        chk("R4 level", int'(d), l);
        rd(A_ISR, d);
        chk("R7 rxrdy", int'(d[1]), (l > t) ? 1 : 0);
      end
      rx_push(8'hEE);
      rd(A_ISR, d);
      chk("R5 ovf flag", int'(d[4]), 1);
      rd(A_RLVL, d);
      chk("R5 level kept", int'(d), DEPTH);
      for (int k = 0; k < DEPTH; k++) begin
        rd(A_RXD, d);
        chk("R4 order", int'(d), 'h40 + t * 8 + k);
      end
      rd(A_RXD, d);
      chk("R4 empty read", int'(d), 0);
      wr(A_ISR, 32'h10);
      rd(A_ISR, d);
      chk("R8 ovf cleared", int'(d[4]), 0);
      wr(A_CTRL, 32'h0);
    end

    // R8 sticky flags, write-1-to-clear
    wr(A_CTRL, 32'h1);
    pulse(1, 1);
    repeat (3) @(posedge clk);
    rd(A_ISR, d); chk("R8 set", int'(d), 'h0D);
    wr(A_ISR, 32'h08);
    rd(A_ISR, d); chk("R8 clr arb", int'(d), 'h05);
    wr(A_ISR, 32'h03);
    rd(A_ISR, d); chk("R8 live bits", int'(d), 'h05);
    wr(A_ISR, 32'h04);
    rd(A_ISR, d); chk("R8 clr nack", int'(d), 'h01);

    // R9 interrupt mask sweep, status 0x0D
    pulse(1, 1);
    for (int m = 0; m < 32; m++) begin
      wr(A_IEN, 32'(m));
      @(negedge clk);
      chk("R9 irq", int'(irq), ((m & 'h0D) != 0) ? 1 : 0);
    end
    rd(A_IEN, d);
    chk("R9 ien readback", int'(d), 31);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule